// File: doc/BRIEF.md
# Prioritised Nesting Interrupt Controller

This block collects a set of maskable interrupt request lines and a few non-maskable trap lines, latches each request in a sticky pending flag, and forwards the most urgent eligible one to a processor core as a vector number with a request strobe. Maskable sources must be switched on in an enable register and given a non-zero level in a per-source 3-bit priority register. Trap sources ignore the enable register and always outrank every maskable level.

The block keeps the level of the service routine now running. A new request reaches the core only when its level is strictly above that in-service level, so routines nest by priority. When the core acknowledges a request, the old in-service level is pushed onto a small stack and the winner's level becomes current. A return pulse pops the stack. Pending flags are cleared only by software, so a source left pending at return is requested again at once.

Software uses a simple single-cycle write bus and a combinational read bus. The register addresses are: 0 enable, 1 maskable pending (write 1 to clear), 2 trap pending (write 1 to clear), 3 in-service level (read only), 4 stack depth (read only), 8+i priority of maskable source i.

Top module: `prio_nest_intc`

## Requirements
- R1: After reset, the enable register, both pending registers, the in-service level and the stack depth read 0, every priority register reads 1, and int_req is low.
- R2: A maskable source i is eligible only when its pending bit, its enable bit (bit i of address 0) and its priority (address 8+i) are all non-zero. Priority 0 disables the source.
- R3: A pending bit is set on any cycle its input is high and stays set until a 1 is written to its bit at address 1 (maskable) or address 2 (traps). If a set and a clear land in the same cycle, the set wins.
- R4: A pending trap j ignores the enable register, has the fixed level 8 (above every maskable level) and is presented as vector N_IRQ+j. Maskable source i is presented as vector i.
- R5: Among eligible sources the highest level wins. Ties go to the lower vector index, so with the reset priorities the lowest-numbered source wins.
- R6: int_req is high only when the winner's level is strictly greater than the in-service level. A request of equal or lower level waits.
- R7: An int_ack pulse while int_req is high (and int_ret low) pushes the in-service level, makes the winner's level current (readable at address 3) and raises the depth (address 4) by one.
- R8: An int_ret pulse restores the most recently pushed level and lowers the depth by one. A source still pending above the restored level is requested again in the very next cycle.
- R9: The stack holds STACK_DEPTH (4) entries. While it is full int_req stays low and int_ack has no effect. int_ret on an empty stack has no effect.
- R10: The enable and priority registers read back the values last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_IRQ | Maskable request lines, active high |
| trap_in | input | N_TRAP | Non-maskable trap lines, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| int_req | output | 1 | Interrupt request to the core |
| int_vector | output | VEC_W | Vector number of the winning source |
| int_ack | input | 1 | Core has taken the presented vector |
| int_ret | input | 1 | Core has returned from the current routine |

## Verification
The bench sweeps every combination of pending maskable sources under three priority assignments: one that includes level 0, one with a partial enable mask, and one where all levels tie. In each case it compares the vector with one computed in the bench. A design that broke ties toward the higher index, or that let a level-0 or disabled source win, would show a wrong vector or a request that should not exist. A scripted nesting sequence checks that equal and lower levels wait, that a trap preempts a running routine, and that a flag left pending re-requests right after return. A controller that compared with "greater or equal" would raise the request again right after each acknowledge. The stack is filled to four entries to show that requests and acknowledges are held off when it is full. Extra returns are sent on an empty stack, where a design without guards would wrap the depth counter.

// File: rtl/pnic_pkg.sv
// Shared constants and types for the prioritised nesting interrupt controller.
// Assumes a 4-bit register address and 8-bit register data.
package pnic_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int PRIO_W = 3;
    localparam int LVL_W  = PRIO_W + 1;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    // Traps sit one level above the largest programmable level.
    localparam lvl_t  TRAP_LVL   = lvl_t'(1 << PRIO_W);
    localparam prio_t PRIO_RESET = prio_t'(1);

    localparam logic [ADDR_W-1:0] A_ENABLE    = 4'd0;
    localparam logic [ADDR_W-1:0] A_PEND      = 4'd1;
    localparam logic [ADDR_W-1:0] A_TRAP      = 4'd2;
    localparam logic [ADDR_W-1:0] A_LEVEL     = 4'd3;
    localparam logic [ADDR_W-1:0] A_DEPTH     = 4'd4;
    localparam int                A_PRIO_BASE = 8;
endpackage

// File: rtl/pnic_regs.sv
// Register file: enable mask, sticky pending flags and per-source priorities,
// plus the combinational read mux. Assumes N_IRQ <= 8 and N_TRAP <= 8.
module pnic_regs
    import pnic_pkg::*;
#(
    parameter int N_IRQ   = 8,
    parameter int N_TRAP  = 2,
    parameter int DEPTH_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IRQ-1:0]        irq_in,
    input  logic [N_TRAP-1:0]       trap_in,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  lvl_t                    cur_lvl,
    input  logic [DEPTH_W-1:0]      depth,
    output logic [N_IRQ-1:0]        en_q,
    output logic [N_IRQ-1:0]        pend_q,
    output logic [N_TRAP-1:0]       tpend_q,
    output logic [N_IRQ-1:0][PRIO_W-1:0] prio_q
);
    logic [N_IRQ-1:0]  pend_clr;
    logic [N_TRAP-1:0] tpend_clr;

    // Decode write-one-to-clear strobes for both pending registers.
    always_comb begin
        pend_clr  = (bus_we && bus_addr == A_PEND) ? bus_wdata[N_IRQ-1:0]  : '0;
        tpend_clr = (bus_we && bus_addr == A_TRAP) ? bus_wdata[N_TRAP-1:0] : '0;
    end

    // Sticky pending flags; a new request beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            tpend_q <= '0;
        end else begin
            pend_q  <= (pend_q & ~pend_clr) | irq_in;
            tpend_q <= (tpend_q & ~tpend_clr) | trap_in;
        end
    end

    // Enable mask, all sources off out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (bus_we && bus_addr == A_ENABLE)
            en_q <= bus_wdata[N_IRQ-1:0];
    end

    // One priority register per maskable source.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_prio
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(A_PRIO_BASE + i);
        // Hold the programmed level of source i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[i] <= PRIO_RESET;
            else if (bus_we && bus_addr == MY_ADDR)
                prio_q[i] <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Read mux for all software-visible state.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ENABLE: bus_rdata[N_IRQ-1:0]  = en_q;
            A_PEND:   bus_rdata[N_IRQ-1:0]  = pend_q;
            A_TRAP:   bus_rdata[N_TRAP-1:0] = tpend_q;
            A_LEVEL:  bus_rdata[LVL_W-1:0]  = cur_lvl;
            A_DEPTH:  bus_rdata[DEPTH_W-1:0] = depth;
            default: begin
                for (int i = 0; i < N_IRQ; i++)
                    if (bus_addr == ADDR_W'(A_PRIO_BASE + i))
                        bus_rdata[PRIO_W-1:0] = prio_q[i];
            end
        endcase
    end
endmodule

// File: rtl/pnic_arbiter.sv
// Combinational winner selection. Scans vectors in ascending order and
// replaces the best only on a strictly higher level, so ties go to the
// lower vector. Traps follow the maskable sources in vector order.
module pnic_arbiter
    import pnic_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int N_TRAP = 2,
    parameter int VEC_W  = 4
) (
    input  logic [N_IRQ-1:0]             en_q,
    input  logic [N_IRQ-1:0]             pend_q,
    input  logic [N_TRAP-1:0]            tpend_q,
    input  logic [N_IRQ-1:0][PRIO_W-1:0] prio_q,
    output logic                         win_valid,
    output logic [VEC_W-1:0]             win_vec,
    output lvl_t                         win_lvl
);
    lvl_t src_lvl [N_IRQ];

    // Effective level of each maskable source, zero when not eligible.
    always_comb begin
        for (int i = 0; i < N_IRQ; i++)
            src_lvl[i] = (pend_q[i] && en_q[i]) ? {1'b0, prio_q[i]} : '0;
    end

    // Priority scan over all vectors.
    always_comb begin
        win_lvl = '0;
        win_vec = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (src_lvl[i] > win_lvl) begin
                win_lvl = src_lvl[i];
                win_vec = VEC_W'(i);
            end
        end
        for (int j = 0; j < N_TRAP; j++) begin
            if (tpend_q[j] && TRAP_LVL > win_lvl) begin
                win_lvl = TRAP_LVL;
                win_vec = VEC_W'(N_IRQ + j);
            end
        end
        win_valid = (win_lvl != '0);
    end
endmodule

// File: rtl/pnic_nest.sv
// In-service level register and save stack. Assumes the caller never pushes
// when full; pop on an empty stack is ignored here.
module pnic_nest
    import pnic_pkg::*;
#(
    parameter int STACK_DEPTH = 4,
    parameter int DEPTH_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  lvl_t               new_lvl,
    output lvl_t               cur_lvl,
    output logic [DEPTH_W-1:0] depth,
    output logic               full
);
    localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

    lvl_t             stk [STACK_DEPTH];
    logic [IDX_W-1:0] push_idx;
    logic [IDX_W-1:0] top_idx;

    // Slot for the next push and the slot holding the newest entry.
    always_comb begin
        push_idx = IDX_W'(depth);
        top_idx  = IDX_W'(depth - 1'b1);
        full     = (depth == DEPTH_W'(STACK_DEPTH));
    end

    // Push on acknowledge, pop on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl <= '0;
            depth   <= '0;
            for (int k = 0; k < STACK_DEPTH; k++) stk[k] <= '0;
        end else if (pop) begin
            if (depth != '0) begin
                cur_lvl <= stk[top_idx];
                depth   <= depth - 1'b1;
            end
        end else if (push) begin
            stk[push_idx] <= cur_lvl;
            cur_lvl       <= new_lvl;
            depth         <= depth + 1'b1;
        end
    end
endmodule

// File: rtl/prio_nest_intc.sv
// Top of the prioritised nesting interrupt controller. Request to the core is
// combinational from registered state; acknowledge is honoured only while the
// request is high, and return takes precedence over a same-cycle acknowledge.
module prio_nest_intc
    import pnic_pkg::*;
#(
    parameter int N_IRQ       = 8,
    parameter int N_TRAP      = 2,
    parameter int STACK_DEPTH = 4,
    localparam int VEC_W      = $clog2(N_IRQ + N_TRAP),
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic [N_TRAP-1:0] trap_in,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              int_req,
    output logic [VEC_W-1:0]  int_vector,
    input  logic              int_ack,
    input  logic              int_ret
);
    logic [N_IRQ-1:0]             en_q;
    logic [N_IRQ-1:0]             pend_q;
    logic [N_TRAP-1:0]            tpend_q;
    logic [N_IRQ-1:0][PRIO_W-1:0] prio_q;
    logic                         win_valid;
    logic [VEC_W-1:0]             win_vec;
    lvl_t                         win_lvl;
    lvl_t                         cur_lvl;
    logic [DEPTH_W-1:0]           depth;
    logic                         full;
    logic                         push;

    pnic_regs #(.N_IRQ(N_IRQ), .N_TRAP(N_TRAP), .DEPTH_W(DEPTH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trap_in(trap_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cur_lvl(cur_lvl), .depth(depth),
        .en_q(en_q), .pend_q(pend_q), .tpend_q(tpend_q), .prio_q(prio_q)
    );

    pnic_arbiter #(.N_IRQ(N_IRQ), .N_TRAP(N_TRAP), .VEC_W(VEC_W)) u_arb (
        .en_q(en_q), .pend_q(pend_q), .tpend_q(tpend_q), .prio_q(prio_q),
        .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl)
    );

    // Present the winner only if it beats the running routine and a slot is free.
    always_comb begin
        int_req    = win_valid && (win_lvl > cur_lvl) && !full;
        int_vector = win_vec;
        push       = int_ack && int_req && !int_ret;
    end

    pnic_nest #(.STACK_DEPTH(STACK_DEPTH), .DEPTH_W(DEPTH_W)) u_nest (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(int_ret),
        .new_lvl(win_lvl), .cur_lvl(cur_lvl), .depth(depth), .full(full)
    );
endmodule

// File: rtl/pnic_checker.sv
// Property checker for prio_nest_intc, attached by bind below.
module pnic_checker
    import pnic_pkg::*;
#(
    parameter int N_IRQ       = 8,
    parameter int N_TRAP      = 2,
    parameter int STACK_DEPTH = 4,
    parameter int VEC_W       = 4,
    parameter int DEPTH_W     = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [3:0]         bus_addr,
    input logic               int_req,
    input logic [VEC_W-1:0]   int_vector,
    input logic               int_ack,
    input logic               int_ret,
    input logic [N_IRQ-1:0]   en_q,
    input logic [N_IRQ-1:0]   pend_q,
    input logic [N_TRAP-1:0]  tpend_q,
    input lvl_t               cur_lvl,
    input logic [DEPTH_W-1:0] depth
);
    localparam logic [VEC_W-1:0]   FIRST_TRAP = VEC_W'(N_IRQ);
    localparam logic [DEPTH_W-1:0] FULL_D     = DEPTH_W'(STACK_DEPTH);

    // R3: without a clear write, no pending bit falls.
    a_r3_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_PEND) |=> (($past(pend_q) & ~pend_q) == '0));

    // R2: a maskable vector needs some enabled pending source behind it.
    a_r2_maskable_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_vector < FIRST_TRAP) |-> ((en_q & pend_q) != '0));

    // R4: a pending trap always wins over a lower running level.
    a_r4_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tpend_q != '0 && cur_lvl < TRAP_LVL && depth < FULL_D)
            |-> (int_req && int_vector >= FIRST_TRAP));

    // R7: an honoured acknowledge raises the level and the depth.
    a_r7_ack_nests: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req && !int_ret)
            |=> (cur_lvl > $past(cur_lvl) && depth == $past(depth) + 1'b1));

    // R8: a return on a non-empty stack lowers the depth by one.
    a_r8_ret_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ret && depth != '0) |=> (depth == $past(depth) - 1'b1));

    // R9: depth never exceeds the stack size.
    a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= FULL_D);

    // R9: no request is raised with a full stack.
    a_r9_full_holds_req: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == FULL_D) |-> !int_req);

    // R9: return on an empty stack leaves it empty.
    a_r9_empty_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ret && depth == '0) |=> (depth == '0 && $stable(cur_lvl)));
endmodule

bind prio_nest_intc pnic_checker #(
    .N_IRQ(N_IRQ), .N_TRAP(N_TRAP), .STACK_DEPTH(STACK_DEPTH),
    .VEC_W(VEC_W), .DEPTH_W(DEPTH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .int_req(int_req), .int_vector(int_vector), .int_ack(int_ack),
    .int_ret(int_ret), .en_q(en_q), .pend_q(pend_q), .tpend_q(tpend_q),
    .cur_lvl(cur_lvl), .depth(depth)
);

// File: tb/prio_nest_intc_test.sv
// Self-checking bench: sweeps all pending patterns under several priority
// settings, then walks a nesting sequence and the stack limits.
module prio_nest_intc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic [1:0] trap_in = '0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       int_req;
    logic [3:0] int_vector;
    logic       int_ack = 1'b0;
    logic       int_ret = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prio_nest_intc uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trap_in(trap_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .int_req(int_req), .int_vector(int_vector),
        .int_ack(int_ack), .int_ret(int_ret)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse_irq(input logic [7:0] p);
        @(negedge clk); irq_in = p;
        @(negedge clk); irq_in = '0;
    endtask

    task automatic pulse_trap(input logic [1:0] p);
        @(negedge clk); trap_in = p;
        @(negedge clk); trap_in = '0;
    endtask

    task automatic do_ack();
        @(negedge clk); int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk); int_ret = 1'b1;
        @(negedge clk); int_ret = 1'b0;
    endtask

    task automatic clear_all();
        wr(4'd1, 8'hFF);
        wr(4'd2, 8'h03);
    endtask

    task automatic see_req(input string req, input int r, input int v);
        #1;
        chk(req, int'(int_req), r);
        if (r != 0) chk(req, int'(int_vector), v);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        int lvl [8];
        logic [7:0] en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1 int_req", int'(int_req), 0);
        rd(4'd0, v); chk("R1 enable", v, 0);
        rd(4'd1, v); chk("R1 pend", v, 0);
        rd(4'd2, v); chk("R1 trap pend", v, 0);
        rd(4'd3, v); chk("R1 level", v, 0);
        rd(4'd4, v); chk("R1 depth", v, 0);
        for (int i = 0; i < 8; i++) begin
            rd(4'(8 + i), v); chk("R1 prio reset", v, 1);
        end

        // R2: pending but disabled raises nothing; R3: flags sticky
        pulse_irq(8'hA5);
        see_req("R2 disabled no req", 0, 0);
        repeat (3) @(negedge clk);
        rd(4'd1, v); chk("R3 sticky pend", v, 8'hA5);
        wr(4'd1, 8'h05);
        rd(4'd1, v); chk("R3 w1c partial", v, 8'hA0);
        // R3: set wins over same-cycle clear
        @(negedge clk);
        irq_in = 8'h01; bus_we = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h01;
        @(negedge clk);
        irq_in = '0; bus_we = 1'b0;
        rd(4'd1, v); chk("R3 set beats clear", v, 8'hA1);
        clear_all();
        rd(4'd1, v); chk("R3 cleared", v, 0);

        // R5 / R2 sweep over all pending patterns and three priority maps
        for (int s = 0; s < 3; s++) begin
            en = (s == 1) ? 8'b1011_0111 : 8'hFF;
            for (int k = 0; k < 8; k++) begin
                lvl[k] = (s == 2) ? 3 : ((k * 5 + s * 3) % 8);
                wr(4'(8 + k), 8'(lvl[k]));
            end
            wr(4'd0, en);
            rd(4'd0, v); chk("R10 enable readback", v, int'(en));
            for (int k = 0; k < 8; k++) begin
                rd(4'(8 + k), v); chk("R10 prio readback", v, lvl[k]);
            end
            for (int p = 0; p < 256; p++) begin
                int best;
                int bv;
                best = 0; bv = 0;
                for (int k = 0; k < 8; k++)
                    if (p[k] && en[k] && lvl[k] > best) begin
                        best = lvl[k]; bv = k;
                    end
                wr(4'd1, 8'hFF);
                pulse_irq(8'(p));
                see_req("R5 sweep winner", (best > 0) ? 1 : 0, bv);
            end
        end

        // R4: traps beat level 7 and ignore enable; lower trap first
        for (int k = 0; k < 8; k++) wr(4'(8 + k), 8'd7);
        for (int t = 1; t < 4; t++) begin
            clear_all();
            wr(4'd0, 8'h00);
            pulse_irq(8'hFF);
            pulse_trap(2'(t));
            see_req("R4 trap bypasses enable", 1, (t[0]) ? 8 : 9);
            wr(4'd0, 8'hFF);
            see_req("R4 trap above level 7", 1, (t[0]) ? 8 : 9);
        end
        clear_all();

        // R6 / R7 / R8 nesting walk
        for (int k = 0; k < 8; k++) wr(4'(8 + k), 8'd1);
        wr(4'd10, 8'd3);
        wr(4'd13, 8'd5);
        pulse_irq(8'h04);
        see_req("R6 first request", 1, 2);
        do_ack();
        rd(4'd3, v); chk("R7 level after ack", v, 3);
        see_req("R6 same source waits", 0, 0);
        pulse_irq(8'h02);
        see_req("R6 lower waits", 0, 0);
        wr(4'd9, 8'd3);
        see_req("R6 equal waits", 0, 0);
        pulse_irq(8'h20);
        see_req("R6 higher preempts", 1, 5);
        do_ack();
        rd(4'd3, v); chk("R7 nested level", v, 5);
        rd(4'd4, v); chk("R7 depth 2", v, 2);
        pulse_trap(2'b01);
        see_req("R4 trap preempts", 1, 8);
        do_ack();
        rd(4'd3, v); chk("R7 trap level", v, 8);
        do_ret();
        rd(4'd3, v); chk("R8 level restored", v, 5);
        see_req("R8 uncleared trap re-requests", 1, 8);
        wr(4'd2, 8'h01);
        see_req("R6 after trap clear", 0, 0);
        do_ret();
        rd(4'd3, v); chk("R8 second restore", v, 3);
        see_req("R8 pending source re-requests", 1, 5);
        wr(4'd1, 8'h20);
        see_req("R6 equal levels wait", 0, 0);
        do_ret();
        rd(4'd3, v); chk("R8 back to idle", v, 0);
        see_req("R5 tie to lower vector", 1, 1);
        clear_all();

        // R9: stack full and empty limits
        for (int k = 0; k < 5; k++) wr(4'(8 + k), 8'(k + 1));
        for (int k = 0; k < 4; k++) begin
            pulse_irq(8'(1 << k));
            see_req("R9 fill request", 1, k);
            do_ack();
            rd(4'd3, v); chk("R9 fill level", v, k + 1);
        end
        rd(4'd4, v); chk("R9 depth full", v, 4);
        pulse_irq(8'h10);
        see_req("R9 full holds higher irq", 0, 0);
        pulse_trap(2'b10);
        see_req("R9 full holds trap", 0, 0);
        do_ack();
        rd(4'd3, v); chk("R9 ack ignored level", v, 4);
        rd(4'd4, v); chk("R9 ack ignored depth", v, 4);
        do_ret();
        rd(4'd3, v); chk("R9 pop from full", v, 3);
        see_req("R9 trap after pop", 1, 9);
        clear_all();
        for (int k = 0; k < 3; k++) do_ret();
        rd(4'd4, v); chk("R9 emptied", v, 0);
        do_ret();
        rd(4'd4, v); chk("R9 empty ret depth", v, 0);
        rd(4'd3, v); chk("R9 empty ret level", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule